// File: doc/BRIEF.md
# Time-Calendar Counter

This block holds the time of day and the calendar in seven one-byte fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second tick input advances the whole set by one second. All carries are handled in one step, including months of 28, 29, 30 and 31 days and the wrap of the year from 99 back to 00. The fields are kept in the host's chosen representation, either plain binary or packed BCD. Hours follow either a 24-hour count or a 12-hour count in which a flag bit marks the afternoon.

A host reaches the fields and a small control byte through a register port. It writes a byte with a one-cycle write strobe and reads through an address-selected data output. To load a new time, the host first sets the halt bit, then writes the format bits and the fields, then clears halt. Every completed advance raises a one-cycle done strobe. Other logic can use that strobe to run alarm comparisons on the new values.

Top module: `tcal_counter`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01, year 0x00. The control byte reads 0x05 (halted, BCD, 24-hour), and the done strobe is low.
- R2: Addresses 0 to 6 select seconds, minutes, hours, day of week, day of month, month and year. Address 7 is the control byte, where bit 0 is halt, bit 1 selects binary (0 selects BCD) and bit 2 selects the 24-hour count (0 selects 12-hour). A written byte reads back unchanged from the next cycle on, except as R3 states, and control bits 7..3 read as 0.
- R3: Bit 7 of the seconds field cannot be written and always reads 0.
- R4: While halt is 1, ticks change no field and raise no done strobe.
- R5: A tick with halt 0 adds one second. Seconds wrap 59→0 into minutes, minutes wrap 59→0 into hours, and hours wrap 23→0 into the next day. A new day moves day of week 7→1 and day of month past the month's last day to 1. Month 12 wraps to 1 into the year, and year 99 wraps to 00.
- R6: In BCD mode each field holds two decimal digits, tens in bits 7..4 and units in bits 3..0. In binary mode each field holds the plain value, so nine seconds plus one tick reads 0x10 in BCD and 0x0A in binary.
- R7: In 12-hour mode the hours field holds 1 to 12 in bits 6..0, with bit 7 set for PM. The order is 12 AM, 1 AM … 11 AM, 12 PM, 1 PM … 11 PM. 11 AM steps to 12 PM, and 11 PM steps to 12 AM of the next day.
- R8: February has 29 days when the year is divisible by four (year 00 included) and 28 days otherwise. April, June, September and November have 30 days.
- R9: The done strobe is high for exactly the one cycle that follows the clock edge at which an advance took place, and the new field values are readable in that same cycle.
- R10: A host write in the same cycle as a tick takes effect, and that tick is dropped: no field advances and no done strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock internally |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| host_we | input | 1 | Write strobe for the addressed byte |
| host_addr | input | 3 | Field or control byte select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the addressed byte, combinational |
| upd_done | output | 1 | One-cycle strobe after each completed advance |

## Verification
Some properties are checked on every clock cycle. The seconds field never shows bit 7. Halt with no write freezes every field. A done strobe only follows a tick that was not overridden by a write, and it never follows any write. A control write reads back on the next cycle. Every advance in 12-hour mode leaves a non-zero hour. The carry chain, the month lengths and leap years, the year wrap, the two encodings and the 12-hour AM/PM order depend on particular starting values. Only the bench's scenarios can show those, by comparing every byte against a behavioural model on each cycle.

// File: rtl/tcal_pkg.sv
package tcal_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_W    = 7;
  localparam int unsigned NFIELD   = 7;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned CTL_W    = 3;

  localparam int unsigned SEC_MAX  = 59;
  localparam int unsigned MIN_MAX  = 59;
  localparam int unsigned HR_MAX   = 23;
  localparam int unsigned DOW_MAX  = 7;
  localparam int unsigned MON_MAX  = 12;
  localparam int unsigned YR_MAX   = 99;
  localparam int unsigned HALF_DAY = 12;

  localparam logic [ADDR_W-1:0] A_SEC = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN = 3'd1;
  localparam logic [ADDR_W-1:0] A_HR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW = 3'd3;
  localparam logic [ADDR_W-1:0] A_DAY = 3'd4;
  localparam logic [ADDR_W-1:0] A_MON = 3'd5;
  localparam logic [ADDR_W-1:0] A_YR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTL = 3'd7;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [NUM_W-1:0]  num_t;

  typedef struct packed {
    num_t yr;
    num_t mon;
    num_t day;
    num_t dow;
    num_t hr;
    num_t min;
    num_t sec;
  } tcal_bin_t;

  typedef struct packed {
    logic h24;
    logic bin;
    logic halt;
  } tcal_ctl_t;

  localparam logic [NFIELD-1:0][BYTE_W-1:0] FIELD_RST =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam tcal_ctl_t CTL_RST   = '{h24: 1'b1, bin: 1'b0, halt: 1'b1};
  localparam byte_t     SEC_WMASK = 8'h7F;
  localparam num_t      NUM_ONE   = 7'd1;

  function automatic num_t bcd_to_bin(input byte_t v);
    num_t hi;
    num_t lo;
    hi = num_t'(v[7:4]);
    lo = num_t'(v[3:0]);
    return hi * num_t'(10) + lo;
  endfunction

  function automatic byte_t bin_to_bcd(input num_t n);
    num_t tens;
    num_t ones;
    tens = n / num_t'(10);
    ones = n % num_t'(10);
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic num_t month_len(input num_t m, input logic leap);
    num_t len;
    case (m)
      7'd2:                    len = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: len = 7'd30;
      default:                 len = 7'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/tcal_rst_sync.sv
module tcal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/tcal_decode.sv
module tcal_decode
  import tcal_pkg::*;
(
  input  logic [NFIELD-1:0][BYTE_W-1:0] raw_i,
  input  tcal_ctl_t                     ctl_i,
  output tcal_bin_t                     val_o
);

  num_t [NFIELD-1:0] num;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    byte_t src;
    if (g == int'(A_HR)) begin : g_hr
      assign src = {1'b0, raw_i[g][BYTE_W-2:0]};
    end else begin : g_plain
      assign src = raw_i[g];
    end
    assign num[g] = ctl_i.bin ? src[NUM_W-1:0] : bcd_to_bin(src);
  end

  logic pm;
  num_t h_clock;
  num_t h_base;

  always_comb begin
    pm      = raw_i[A_HR][BYTE_W-1];
    h_clock = num[A_HR];
    h_base  = (h_clock == num_t'(HALF_DAY)) ? '0 : h_clock;
    val_o.sec = num[A_SEC];
    val_o.min = num[A_MIN];
    val_o.hr  = ctl_i.h24 ? h_clock : (h_base + (pm ? num_t'(HALF_DAY) : '0));
    val_o.dow = num[A_DOW];
    val_o.day = num[A_DAY];
    val_o.mon = num[A_MON];
    val_o.yr  = num[A_YR];
  end

endmodule

// File: rtl/tcal_step.sv
module tcal_step
  import tcal_pkg::*;
(
  input  tcal_bin_t cur_i,
  output tcal_bin_t nxt_o
);

  logic leap;
  num_t dim;
  logic c_min;
  logic c_hr;
  logic c_day;
  logic c_mon;
  logic c_yr;

  always_comb begin
    leap  = (cur_i.yr[1:0] == 2'b00);
    dim   = month_len(cur_i.mon, leap);
    c_min = (cur_i.sec >= num_t'(SEC_MAX));
    c_hr  = c_min && (cur_i.min >= num_t'(MIN_MAX));
    c_day = c_hr  && (cur_i.hr  >= num_t'(HR_MAX));
    c_mon = c_day && (cur_i.day >= dim);
    c_yr  = c_mon && (cur_i.mon >= num_t'(MON_MAX));

    nxt_o.sec = c_min ? '0 : cur_i.sec + NUM_ONE;
    nxt_o.min = c_hr  ? '0 : (c_min ? cur_i.min + NUM_ONE : cur_i.min);
    nxt_o.hr  = c_day ? '0 : (c_hr  ? cur_i.hr  + NUM_ONE : cur_i.hr);
    nxt_o.dow = c_day ? ((cur_i.dow >= num_t'(DOW_MAX)) ? NUM_ONE : cur_i.dow + NUM_ONE)
                      : cur_i.dow;
    nxt_o.day = c_mon ? NUM_ONE : (c_day ? cur_i.day + NUM_ONE : cur_i.day);
    nxt_o.mon = c_yr  ? NUM_ONE : (c_mon ? cur_i.mon + NUM_ONE : cur_i.mon);
    nxt_o.yr  = c_yr  ? ((cur_i.yr >= num_t'(YR_MAX)) ? '0 : cur_i.yr + NUM_ONE)
                      : cur_i.yr;
  end

endmodule

// File: rtl/tcal_encode.sv
module tcal_encode
  import tcal_pkg::*;
(
  input  tcal_bin_t                     val_i,
  input  tcal_ctl_t                     ctl_i,
  output logic [NFIELD-1:0][BYTE_W-1:0] raw_o
);

  num_t [NFIELD-1:0] num;
  logic pm;
  num_t h12;

  always_comb begin
    pm  = (val_i.hr >= num_t'(HALF_DAY));
    h12 = pm ? (val_i.hr - num_t'(HALF_DAY)) : val_i.hr;
    if (h12 == '0) h12 = num_t'(HALF_DAY);
    num[A_SEC] = val_i.sec;
    num[A_MIN] = val_i.min;
    num[A_HR]  = ctl_i.h24 ? val_i.hr : h12;
    num[A_DOW] = val_i.dow;
    num[A_DAY] = val_i.day;
    num[A_MON] = val_i.mon;
    num[A_YR]  = val_i.yr;
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    byte_t coded;
    assign coded = ctl_i.bin ? {1'b0, num[g]} : bin_to_bcd(num[g]);
    if (g == int'(A_HR)) begin : g_hr
      assign raw_o[g] = coded | {(pm & ~ctl_i.h24), {(BYTE_W-1){1'b0}}};
    end else begin : g_plain
      assign raw_o[g] = coded;
    end
  end

endmodule

// File: rtl/tcal_counter.sv
module tcal_counter
  import tcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              upd_done
);

  logic rst_sync_n;

  tcal_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  logic [NFIELD-1:0][BYTE_W-1:0] fld_q;
  logic [NFIELD-1:0][BYTE_W-1:0] adv_raw;
  tcal_ctl_t ctl_q;
  tcal_ctl_t ctl_d;
  tcal_bin_t cur_bin;
  tcal_bin_t nxt_bin;
  logic      adv_en;
  logic      ctl_we;
  logic      done_q;
  logic      done_d;

  tcal_decode u_dec (
    .raw_i (fld_q),
    .ctl_i (ctl_q),
    .val_o (cur_bin)
  );

  tcal_step u_step (
    .cur_i (cur_bin),
    .nxt_o (nxt_bin)
  );

  tcal_encode u_enc (
    .val_i (nxt_bin),
    .ctl_i (ctl_q),
    .raw_o (adv_raw)
  );

  assign adv_en = sec_tick & ~ctl_q.halt & ~host_we;
  assign ctl_we = host_we & (host_addr == A_CTL);

  for (genvar g = 0; g < NFIELD; g++) begin : g_reg
    logic  wr_hit;
    logic  fld_en;
    byte_t fld_d;
    byte_t q;
    assign wr_hit = host_we & (host_addr == ADDR_W'(g));
    assign fld_en = wr_hit | adv_en;

    always_comb begin
      if (wr_hit) fld_d = (g == int'(A_SEC)) ? (host_wdata & SEC_WMASK) : host_wdata;
      else        fld_d = adv_raw[g];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  q <= FIELD_RST[g];
      else if (fld_en)  q <= fld_d;
    end

    assign fld_q[g] = q;
  end

  always_comb begin
    ctl_d  = ctl_we ? tcal_ctl_t'(host_wdata[CTL_W-1:0]) : ctl_q;
    done_d = adv_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctl_q <= CTL_RST;
    else if (ctl_we)  ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign upd_done = done_q;

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < int'(NFIELD); i++) begin
      if (host_addr == ADDR_W'(i)) host_rdata = fld_q[i];
    end
    if (host_addr == A_CTL) host_rdata = {{(BYTE_W-CTL_W){1'b0}}, ctl_q};
  end

  // R3: the seconds top bit never appears in the stored field
  a_r3_sec_top_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fld_q[A_SEC][BYTE_W-1] == 1'b0);

  // R4: halt without a write freezes every field
  a_r4_halt_freezes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_q.halt && !host_we) |=> $stable(fld_q));

  // R9: a done strobe follows only an accepted tick
  a_r9_done_needs_tick: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd_done |-> ($past(sec_tick) && !$past(host_we)));

  // R10: a write cycle is never followed by a done strobe
  a_r10_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_we |=> !upd_done);

  // R2: a control write is visible on the next cycle
  a_r2_ctl_readback: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_we |=> (ctl_q == $past(host_wdata[CTL_W-1:0])));

  // R7: an advance in 12-hour mode never yields hour zero
  a_r7_hour_nonzero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_done && !ctl_q.h24) |-> (fld_q[A_HR][BYTE_W-2:0] != '0));

endmodule

// File: tb/tcal_counter_test.sv
`timescale 1ns/10ps
module tcal_counter_test;

  localparam real CLK_HALF = 4.0;

  logic       clk;
  logic       rst_n;
  logic       sec_tick;
  logic       host_we;
  logic [2:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       upd_done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int m_fld[7];
  bit m_halt, m_bin, m_h24, m_done;

  tcal_counter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .upd_done   (upd_done)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  function automatic int dec(int v);
    return m_bin ? v : ((v >> 4) * 10 + (v & 15));
  endfunction

  function automatic int enc(int n);
    return m_bin ? n : ((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int days_of(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void model_adv();
    int s, mi, hv, hr, dw, dy, mo, yr, h;
    s  = dec(m_fld[0]);
    mi = dec(m_fld[1]);
    hv = dec(m_fld[2] & 127);
    hr = m_h24 ? hv : ((hv % 12) + (((m_fld[2] & 128) != 0) ? 12 : 0));
    dw = dec(m_fld[3]);
    dy = dec(m_fld[4]);
    mo = dec(m_fld[5]);
    yr = dec(m_fld[6]);
    s++;
    if (s >= 60) begin
      s = 0; mi++;
      if (mi >= 60) begin
        mi = 0; hr++;
        if (hr >= 24) begin
          hr = 0;
          dw = (dw >= 7) ? 1 : dw + 1;
          dy++;
          if (dy > days_of(mo, yr)) begin
            dy = 1; mo++;
            if (mo > 12) begin
              mo = 1; yr++;
              if (yr >= 100) yr = 0;
            end
          end
        end
      end
    end
    m_fld[0] = enc(s);
    m_fld[1] = enc(mi);
    if (m_h24) m_fld[2] = enc(hr);
    else begin
      h = hr % 12;
      if (h == 0) h = 12;
      m_fld[2] = enc(h) | ((hr >= 12) ? 128 : 0);
    end
    m_fld[3] = enc(dw);
    m_fld[4] = enc(dy);
    m_fld[5] = enc(mo);
    m_fld[6] = enc(yr);
  endfunction

  function automatic void model_write(int a, int d);
    if (a == 7) begin
      m_halt = d[0];
      m_bin  = d[1];
      m_h24  = d[2];
    end else if (a == 0) m_fld[0] = d & 127;
    else m_fld[a] = d & 255;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic rd(input int a, output int v);
    host_addr = a[2:0];
    #0.3;
    v = host_rdata;
  endtask

  task automatic compare_all(input string tag);
    int v;
    check(tag, "done", upd_done, m_done);
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      if (a < 7) check(tag, $sformatf("byte%0d", a), v, m_fld[a]);
      else       check(tag, "ctl", v, {m_h24, m_bin, m_halt});
    end
  endtask

  task automatic step(input bit tk, input bit we, input int a, input int d, input string tag);
    sec_tick   = tk;
    host_we    = we;
    host_addr  = a[2:0];
    host_wdata = d[7:0];
    @(posedge clk);
    #1;
    m_done = tk && !m_halt && !we;
    if (we) model_write(a, d);
    else if (m_done) model_adv();
    sec_tick = 1'b0;
    host_we  = 1'b0;
    compare_all(tag);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    step(1'b0, 1'b1, a, d, tag);
  endtask

  task automatic tick(input string tag);
    step(1'b1, 1'b0, 0, 0, tag);
    step(1'b0, 1'b0, 0, 0, tag);
  endtask

  task automatic load(input int hr, input int mi, input int s, input int dw,
                      input int dy, input int mo, input int yr, input string tag);
    wr(0, s, tag); wr(1, mi, tag); wr(2, hr, tag); wr(3, dw, tag);
    wr(4, dy, tag); wr(5, mo, tag); wr(6, yr, tag);
  endtask

  task automatic expect_byte(input int a, input int exp, input string tag);
    int v;
    rd(a, v);
    check(tag, $sformatf("direct byte%0d", a), v, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(2.0 * CLK_HALF * 50000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int keep;
    rst_n = 1'b0; sec_tick = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    m_fld = '{0, 0, 0, 1, 1, 1, 0};
    m_halt = 1; m_bin = 0; m_h24 = 1; m_done = 0;
    #21;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");

    // R2, R5: BCD 24-hour, full carry into a new century
    wr(7, 5, "R2");
    load('h23, 'h59, 'h58, 'h07, 'h31, 'h12, 'h99, "R2");
    wr(7, 4, "R2");
    wr(7, 'hF4, "R2");
    tick("R5");
    tick("R5");
    expect_byte(6, 'h00, "R5");
    expect_byte(5, 'h01, "R5");
    expect_byte(4, 'h01, "R5");
    expect_byte(3, 'h01, "R5");
    tick("R5");

    // R4: halted ticks
    wr(7, 5, "R4");
    tick("R4");
    tick("R4");
    step(1'b1, 1'b0, 0, 0, "R4");
    expect_byte(0, 'h01, "R4");

    // R3: seconds top bit
    wr(0, 'hD5, "R3");
    expect_byte(0, 'h55, "R3");

    // R6: BCD units carry
    wr(0, 'h09, "R6");
    wr(7, 4, "R6");
    tick("R6");
    expect_byte(0, 'h10, "R6");

    // R6, R8: binary mode, leap year 4
    wr(7, 7, "R6");
    load(23, 59, 59, 3, 28, 2, 4, "R8");
    wr(7, 6, "R8");
    tick("R8");
    expect_byte(4, 29, "R8");
    expect_byte(5, 2, "R8");
    wr(0, 9, "R6");
    tick("R6");
    expect_byte(0, 'h0A, "R6");

    // R8: year 3 has no Feb 29
    wr(7, 7, "R8");
    load(23, 59, 59, 4, 28, 2, 3, "R8");
    wr(7, 6, "R8");
    tick("R8");
    expect_byte(4, 1, "R8");
    expect_byte(5, 3, "R8");

    // R8: year 00 is a leap year
    wr(7, 7, "R8");
    load(23, 59, 59, 5, 28, 2, 0, "R8");
    wr(7, 6, "R8");
    tick("R8");
    expect_byte(4, 29, "R8");

    // R8: BCD year 96, then 29 Feb rolls to 1 Mar
    wr(7, 5, "R8");
    load('h23, 'h59, 'h59, 'h02, 'h28, 'h02, 'h96, "R8");
    wr(7, 4, "R8");
    tick("R8");
    expect_byte(4, 'h29, "R8");
    wr(7, 5, "R8");
    load('h23, 'h59, 'h59, 'h03, 'h29, 'h02, 'h96, "R8");
    wr(7, 4, "R8");
    tick("R8");
    expect_byte(4, 'h01, "R8");
    expect_byte(5, 'h03, "R8");

    // R5: 30-day month
    wr(7, 5, "R5");
    load('h23, 'h59, 'h59, 'h06, 'h30, 'h04, 'h21, "R5");
    wr(7, 4, "R5");
    tick("R5");
    expect_byte(4, 'h01, "R5");
    expect_byte(5, 'h05, "R5");

    // R7: 12-hour BCD
    wr(7, 1, "R7");
    load('h11, 'h59, 'h59, 'h01, 'h10, 'h06, 'h22, "R7");
    wr(7, 0, "R7");
    tick("R7");
    expect_byte(2, 'h92, "R7");
    wr(7, 1, "R7");
    load('h91, 'h59, 'h59, 'h01, 'h10, 'h06, 'h22, "R7");
    wr(7, 0, "R7");
    tick("R7");
    expect_byte(2, 'h12, "R7");
    expect_byte(4, 'h11, "R7");
    wr(7, 1, "R7");
    load('h12, 'h59, 'h59, 'h01, 'h10, 'h06, 'h22, "R7");
    wr(7, 0, "R7");
    tick("R7");
    expect_byte(2, 'h01, "R7");

    // R7: 12-hour binary, 11 PM to 12 AM
    wr(7, 3, "R7");
    load('h8B, 59, 59, 2, 5, 7, 30, "R7");
    wr(7, 2, "R7");
    tick("R7");
    expect_byte(2, 'h0C, "R7");
    expect_byte(3, 3, "R7");

    // R10: write and tick together
    rd(0, keep);
    step(1'b1, 1'b1, 1, 'h22, "R10");
    expect_byte(0, keep, "R10");
    check("R10", "done", upd_done, 0);
    step(1'b0, 1'b0, 0, 0, "R10");

    // R9: dense tick pattern, checked every cycle
    wr(7, 4, "R9");
    load('h23, 'h58, 'h30, 'h07, 'h31, 'h12, 'h99, "R9");
    for (int i = 0; i < 600; i++) begin
      step((i % 3) != 1, 1'b0, 0, 0, "R9");
    end
    for (int i = 0; i < 200; i++) begin
      step(1'b1, 1'b0, 0, 0, "R9");
    end
    step(1'b0, 1'b0, 0, 0, "R9");
    check("R9", "done after idle", upd_done, 0);

    finish_run();
  end

endmodule